// File: doc/BRIEF.md
# Segment Access Mode Decoder

This block classifies a memory access against the access-mode code of the segment it falls in. It takes the segment's 3-bit access-mode code, the segment's error-unmapped flag and the processor's current privilege level. It returns two results. The first says whether the access must raise an address error. The second says whether the segment is translated through the TLB or passes through unmapped. The block does not translate the address, look up the TLB or raise an exception. It only gives the verdict that the translation logic around it acts on.

There are four privilege levels: kernel, supervisor, user, and kernel with the error level raised. A build parameter selects the output timing. With `OUT_REG` = 1, the outputs are registered on the rising clock edge and cleared by a synchronous reset. With `OUT_REG` = 0, the outputs follow the inputs combinationally.

Top module: `seg_mode_classifier`

## Requirements
- R1: With privMode = 0 (kernel), addrFault is 0 for every amCode, and tlbMapped is 1 exactly for amCode 1, 2 and 3.
- R2: With privMode = 1 (supervisor), addrFault is 1 exactly for amCode 0 and 1, and tlbMapped is 1 exactly for amCode 2, 3 and 4.
- R3: With privMode = 2 (user), addrFault is 1 exactly for amCode 0, 1, 2 and 5, and tlbMapped is 1 exactly for amCode 3 and 4.
- R4: With privMode = 3 (error level) and euFlag = 0, both outputs equal the kernel result (R1) for every amCode.
- R5: With privMode = 3 and euFlag = 1, addrFault and tlbMapped are both 0 for every amCode.
- R6: amCode 7 and the reserved amCode 6 give addrFault = 0 and tlbMapped = 0 at every privilege level and euFlag value.
- R7: Whenever addrFault is 1, tlbMapped is 0.
- R8: For privMode 0, 1 and 2, euFlag has no effect on either output.
- R9: With OUT_REG = 1 (the default), the outputs show the result for the inputs present at the previous rising clock edge. A high rst at a rising edge clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous reset, active high |
| amCode | input | 3 | Segment access-mode code |
| euFlag | input | 1 | Segment is unmapped while the error level is raised |
| privMode | input | 2 | Privilege level: 0 kernel, 1 supervisor, 2 user, 3 error level |
| addrFault | output | 1 | The access raises an address error |
| tlbMapped | output | 1 | The segment is translated through the TLB |

## Verification
The hardest case to reach is the one where euFlag must change the result. It matters only at the error level, and only for the access-mode codes that kernel mode would map. In every other mode the same flag must change nothing. To reach it, the stimulus sweeps every amCode at privMode 3 twice, once with the flag clear and once with it set. It then toggles the flag in each of the other three modes and confirms that the outputs do not move. With the register enabled, a separate scenario changes the inputs between clock edges. It checks that the outputs keep their old value until the next rising edge.

// File: rtl/seg_mode_pkg.sv
package seg_mode_pkg;

  localparam int AM_W = 3;
  localparam int AM_CNT = 1 << AM_W;

  typedef enum logic [1:0] {
    PRIV_KERNEL = 2'd0,
    PRIV_SUPER  = 2'd1,
    PRIV_USER   = 2'd2,
    PRIV_ERRLVL = 2'd3
  } priv_e;

  // Bit n of each mask refers to access-mode code n.
  localparam logic [AM_CNT-1:0] KERN_MAP_MASK = 8'b0000_1110;
  localparam logic [AM_CNT-1:0] SUP_FAULT_MASK = 8'b0000_0011;
  localparam logic [AM_CNT-1:0] SUP_MAP_MASK = 8'b0001_1100;
  localparam logic [AM_CNT-1:0] USR_FAULT_MASK = 8'b0010_0111;
  localparam logic [AM_CNT-1:0] USR_MAP_MASK = 8'b0001_1000;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic selKernel;
    logic selSuper;
    logic selUser;
    logic bypass;
  } seg_strb_t;

endpackage

// File: rtl/seg_mode_ctrl.sv
module seg_mode_ctrl
  import seg_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] privMode,
  input  logic       euFlag,
  output seg_strb_t  strb
);

  always_comb begin
    strb = '0;
    case (priv_e'(privMode))
      PRIV_KERNEL: strb.selKernel = 1'b1;
      PRIV_SUPER:  strb.selSuper = 1'b1;
      PRIV_USER:   strb.selUser = 1'b1;
      PRIV_ERRLVL: begin
        if (euFlag) strb.bypass = 1'b1;
        else        strb.selKernel = 1'b1;
      end
      default:     strb.selKernel = 1'b1;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones(strb) == 1); // R4
  AST_ERRLVL_AS_KERNEL: assert property (@(posedge clk) disable iff (rst)
    (privMode == 2'd3 && !euFlag) |-> strb.selKernel); // R4
  AST_EU_ONLY_AT_ERRLVL: assert property (@(posedge clk) disable iff (rst)
    (privMode != 2'd3) |-> !strb.bypass); // R8

endmodule

// File: rtl/seg_mode_dpath.sv
module seg_mode_dpath
  import seg_mode_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AM_W-1:0] amCode,
  input  seg_strb_t       strb,
  output logic            addrFault,
  output logic            tlbMapped
);

  logic [AM_CNT-1:0] amHot;
  logic [AM_CNT-1:0] faultRow;
  logic [AM_CNT-1:0] mapRow;
  logic rawFault;
  logic rawMap;
  logic finalMap;

  for (genvar g = 0; g < AM_CNT; g++) begin : g_dec
    assign amHot[g] = (amCode == AM_W'(g));
  end

  always_comb begin
    faultRow = '0;
    mapRow = '0;
    if (strb.selKernel) mapRow = mapRow | KERN_MAP_MASK;
    if (strb.selSuper) begin
      faultRow = faultRow | SUP_FAULT_MASK;
      mapRow = mapRow | SUP_MAP_MASK;
    end
    if (strb.selUser) begin
      faultRow = faultRow | USR_FAULT_MASK;
      mapRow = mapRow | USR_MAP_MASK;
    end
  end

  assign rawFault = |(faultRow & amHot);
  assign rawMap = |(mapRow & amHot);
  // An address error takes priority: the mapping verdict is dropped.
  assign finalMap = rawMap & ~rawFault;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        addrFault <= 1'b0;
        tlbMapped <= 1'b0;
      end else begin
        addrFault <= rawFault;
        tlbMapped <= finalMap;
      end
    end
  end else begin : g_comb
    assign addrFault = rawFault;
    assign tlbMapped = finalMap;
  end

  AST_KERNEL_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    strb.selKernel |-> !rawFault); // R1
  AST_BYPASS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    strb.bypass |-> (!rawFault && !finalMap)); // R5
  AST_TOP_CODES_QUIET: assert property (@(posedge clk) disable iff (rst)
    (amHot[7] || amHot[6]) |-> (!rawFault && !finalMap)); // R6
  AST_FAULT_MASKS_MAP: assert property (@(posedge clk) disable iff (rst)
    rawFault |-> !finalMap); // R7
  AST_USER_LOW_FAULT: assert property (@(posedge clk) disable iff (rst)
    (strb.selUser && amCode <= 3'd2) |-> rawFault); // R3

endmodule

// File: rtl/seg_mode_classifier.sv
module seg_mode_classifier
  import seg_mode_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] amCode,
  input  logic       euFlag,
  input  logic [1:0] privMode,
  output logic       addrFault,
  output logic       tlbMapped
);

  seg_strb_t strb;

  seg_mode_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .privMode (privMode),
    .euFlag   (euFlag),
    .strb     (strb)
  );

  seg_mode_dpath #(.OUT_REG(OUT_REG)) i_dpath (
    .clk       (clk),
    .rst       (rst),
    .amCode    (amCode),
    .strb      (strb),
    .addrFault (addrFault),
    .tlbMapped (tlbMapped)
  );

  AST_FAULT_NOT_MAPPED: assert property (@(posedge clk) disable iff (rst)
    addrFault |-> !tlbMapped); // R7

endmodule

// File: tb/test_seg_mode_classifier.sv
module test_seg_mode_classifier;

  localparam bit OUT_REG = 1'b1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] amCode = 3'd0;
  logic euFlag = 1'b0;
  logic [1:0] privMode = 2'd0;
  logic addrFault;
  logic tlbMapped;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  seg_mode_classifier #(.OUT_REG(OUT_REG)) i_seg_mode_classifier (
    .clk(clk), .rst(rst), .amCode(amCode), .euFlag(euFlag),
    .privMode(privMode), .addrFault(addrFault), .tlbMapped(tlbMapped)
  );

  // Reference model written from the requirements.
  function automatic void refModel(input int am, input bit eu, input int md,
                                   output bit f, output bit m);
    f = 1'b0;
    m = 1'b0;
    case (md)
      0: m = (am >= 1 && am <= 3);                           // R1
      1: begin f = (am <= 1); m = (am >= 2 && am <= 4); end  // R2
      2: begin f = (am <= 2 || am == 5); m = (am == 3 || am == 4); end // R3
      default: if (!eu) m = (am >= 1 && am <= 3);            // R4, R5
    endcase
  endfunction

  task automatic check(input string req, input bit actF, input bit actM,
                       input bit expF, input bit expM);
    checks++;
    if (actF !== expF || actM !== expM) begin
      fails++;
      $display("FAIL %s: got fault=%b mapped=%b, expected fault=%b mapped=%b",
               req, actF, actM, expF, expM);
    end
  endtask

  task automatic apply(input int am, input bit eu, input int md);
    @(negedge clk);
    amCode = 3'(am);
    euFlag = eu;
    privMode = 2'(md);
    @(posedge clk);
    #1;
  endtask

  task automatic sweepMode(input string req, input int md, input bit eu);
    bit f, m;
    for (int a = 0; a < 8; a++) begin
      apply(a, eu, md);
      refModel(a, eu, md, f, m);
      check(req, addrFault, tlbMapped, f, m);
    end
  endtask

  task automatic testReset();
    apply(3, 1'b0, 0);  // would map if reset were not applied
    check("R9", addrFault, tlbMapped, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic testKernel();    sweepMode("R1", 0, 1'b0); endtask
  task automatic testSuper();     sweepMode("R2", 1, 1'b0); endtask
  task automatic testUser();      sweepMode("R3", 2, 1'b0); endtask
  task automatic testErrLvlEu0(); sweepMode("R4", 3, 1'b0); endtask
  task automatic testErrLvlEu1(); sweepMode("R5", 3, 1'b1); endtask

  task automatic testEuIgnored();
    bit f, m;
    for (int md = 0; md < 3; md++)
      for (int a = 0; a < 8; a++) begin
        apply(a, 1'b1, md);
        refModel(a, 1'b0, md, f, m);
        check("R8", addrFault, tlbMapped, f, m);
      end
  endtask

  task automatic testTopCodes();
    for (int md = 0; md < 4; md++)
      for (int e = 0; e < 2; e++)
        for (int a = 6; a < 8; a++) begin
          apply(a, e[0], md);
          check("R6", addrFault, tlbMapped, 1'b0, 1'b0);
        end
  endtask

  task automatic testFaultPriority();
    for (int md = 0; md < 4; md++)
      for (int a = 0; a < 8; a++) begin
        apply(a, 1'b0, md);
        checks++;
        if (addrFault && tlbMapped) begin
          fails++;
          $display("FAIL R7: got fault=1 mapped=1, expected mapped=0");
        end
      end
  endtask

  task automatic testLatency();
    if (OUT_REG) begin
      apply(0, 1'b0, 2);             // user, code 0: fault
      check("R9", addrFault, tlbMapped, 1'b1, 1'b0);
      @(negedge clk);
      amCode = 3'd3;                 // user, code 3: mapped
      #1;
      check("R9", addrFault, tlbMapped, 1'b1, 1'b0);
      @(posedge clk);
      #1;
      check("R9", addrFault, tlbMapped, 1'b0, 1'b1);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #1;
      check("R9", addrFault, tlbMapped, 1'b0, 1'b0);
      @(negedge clk);
      rst = 1'b0;
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    testReset();
    testKernel();
    testSuper();
    testUser();
    testErrLvlEu0();
    testErrLvlEu1();
    testEuIgnored();
    testTopCodes();
    testFaultPriority();
    testLatency();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule